// File: doc/BRIEF.md
# Multiplexed Address Latch and Memory Interface

This block connects an 8-bit processor bus with a time-shared address bus to on-board memory. Early in each machine cycle the address lines carry the upper address byte; later they carry the lower byte. The block captures the upper byte when the first timing pulse ends. It joins that byte to the live lower byte to form a 16-bit memory address, and it decodes the captured byte into one chip select per configured address range.

Data flows towards the processor only while the read strobe is asserted and a range is selected. A write strobe that is not asserted never counts as a read. Early in a write cycle another source is driving the shared bus, so the block must stay off it. A write is committed when the write strobe ends. The block then gives a one-cycle write enable to the memory, with the address and data held from the last cycle in which the strobe was active.

All inputs are taken as already synchronous to `clk`. Each strobe and select has a parameter that sets its polarity: "N" style (asserted at ground) or "P" style (asserted at the high level).

Top module: `mem_bus_if`

## Requirements
- R1: After reset the upper address byte is 0x00, every chip select is deasserted, the drive enable is low, the write enable is low and `dbus_o` is zero.
- R2: The upper byte is the address-bus value sampled in the last clock cycle in which `tpa_i` was high. It is captured when `tpa_i` is first seen low, appears on `addr_o[15:8]` one cycle later, and is held until the next falling edge of `tpa_i`.
- R3: `addr_o[7:0]` follows `abus_i` combinationally, without a latch, while `addr_o[15:8]` is unaffected by it.
- R4: With default parameters, range 0 covers upper bytes 0x00–0x1F (`cs_o[0]`) and range 1 covers 0x20–0x7F (`cs_o[1]`). Upper bytes 0x80–0xFF select nothing. At most one select is asserted, and on overlap the lowest index wins.
- R5: Chip selects change only in the cycle after a falling edge of `tpa_i`. None is asserted before the first such edge.
- R6: `dbus_oe_o` is high only while the read strobe is asserted and a range is selected, combinationally in that same cycle. `dbus_o` then equals `mem_rdata_i`, and is zero otherwise.
- R7: Throughout a write cycle, including the part where the bus carries write data but no strobe is asserted yet, `dbus_oe_o` stays low.
- R8: When the write strobe is seen deasserted after being asserted, `mem_we_o` pulses high for exactly one cycle, in the cycle after the first inactive sample. It carries `mem_waddr_o`/`mem_wdata_o` from the last active-strobe cycle, and it pulses only if a range was selected then.
- R9: With default parameters both strobes and all chip selects are active-low (asserted at 0). Parameters `RD_ACT_LOW`, `WR_ACT_LOW` and `CS_ACT_LOW` set to 0 make them active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpa_i | input | 1 | First timing pulse; its falling edge captures the upper byte |
| abus_i | input | 8 | Multiplexed address bus |
| rd_strb_i | input | 1 | Memory read strobe (polarity by `RD_ACT_LOW`) |
| wr_strb_i | input | 1 | Memory write strobe (polarity by `WR_ACT_LOW`) |
| dbus_i | input | 8 | Shared data bus as seen by the block |
| mem_rdata_i | input | 8 | Read data from the memory arrays |
| addr_o | output | 16 | Full memory address {upper latched, lower live} |
| cs_o | output | N_RGN | Chip selects, one per range (polarity by `CS_ACT_LOW`) |
| mem_we_o | output | 1 | One-cycle memory write enable |
| mem_waddr_o | output | 16 | Address of the committed write |
| mem_wdata_o | output | 8 | Data of the committed write |
| dbus_oe_o | output | 1 | Data-bus drive enable |
| dbus_o | output | 8 | Data driven to the bus when enabled |

## Verification
The results come due at different times:
- The drive enable, `dbus_o` and the lower address byte respond combinationally, so they are checked in the same clock cycle in which the stimulus is applied.
- The upper byte and the chip selects pass through a single register stage after the cycle in which `tpa_i` is first low. The bench therefore checks that they are unchanged in that cycle and updated in the next one.
- The write enable comes two cycles after the last active-strobe cycle. It is checked low in the cycle the strobe drops, high one cycle later, and low again after that.

The bench drives inputs just after each rising edge and samples just before the following one, so every check lands on a known side of each register.

// File: rtl/mem_bus_pkg.sv
package mem_bus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Convert a pin level into its asserted meaning.
  function automatic logic lvl_to_act(input logic lvl, input logic act_low);
    return act_low ? ~lvl : lvl;
  endfunction
endpackage

// File: rtl/hi_byte_latch.sv
module hi_byte_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tpa_i,
  input  logic [W-1:0] abus_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] hi_next_o,
  output logic         fall_o
);
  logic         tpa_q;
  logic [W-1:0] abus_q;
  logic [W-1:0] hi_q, hi_n;
  logic         fall;

  // Trailing edge: pulse was high last cycle, low now.
  assign fall = tpa_q & ~tpa_i;

  always_comb begin
    hi_n = hi_q;
    if (fall) hi_n = abus_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpa_q  <= 1'b0;
      abus_q <= '0;
      hi_q   <= '0;
    end else begin
      tpa_q  <= tpa_i;
      abus_q <= abus_i;
      hi_q   <= hi_n;
    end
  end

  assign hi_o      = hi_q;
  assign hi_next_o = abus_q;
  assign fall_o    = fall;
endmodule

// File: rtl/range_decoder.sv
module range_decoder #(
  parameter int unsigned           W      = 8,
  parameter int unsigned           N      = 2,
  parameter logic [N*W-1:0]        BASES  = '0,
  parameter logic [N*W-1:0]        LASTS  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] page_i,
  output logic [N-1:0] sel_o
);
  logic [N-1:0] hit;
  logic [N-1:0] pick;
  logic [N-1:0] sel_q, sel_n;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    localparam logic [W-1:0] LO = BASES[g*W +: W];
    localparam logic [W-1:0] HI = LASTS[g*W +: W];
    assign hit[g] = (page_i >= LO) && (page_i <= HI);
  end

  // Lowest index wins on overlap.
  always_comb begin
    logic taken;
    taken = 1'b0;
    pick  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (hit[i] && !taken) begin
        pick[i] = 1'b1;
        taken   = 1'b1;
      end
    end
  end

  always_comb begin
    sel_n = sel_q;
    if (load_i) sel_n = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_n;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/wr_commit.sv
module wr_commit #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act_i,
  input  logic          sel_any_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  logic          wr_q;
  logic          wsel_q, wsel_n;
  logic [AW-1:0] wa_q, wa_n;
  logic [DW-1:0] wd_q, wd_n;
  logic          we_q, we_n;

  always_comb begin
    wa_n   = wa_q;
    wd_n   = wd_q;
    wsel_n = wsel_q;
    if (wr_act_i) begin
      wa_n   = addr_i;
      wd_n   = data_i;
      wsel_n = sel_any_i;
    end
    // Commit on the strobe's trailing edge only.
    we_n = wr_q & ~wr_act_i & wsel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wsel_q <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
    end else begin
      wr_q   <= wr_act_i;
      wsel_q <= wsel_n;
      wa_q   <= wa_n;
      wd_q   <= wd_n;
      we_q   <= we_n;
    end
  end

  assign we_o    = we_q;
  assign waddr_o = wa_q;
  assign wdata_o = wd_q;
endmodule

// File: rtl/mem_bus_if.sv
module mem_bus_if
  import mem_bus_pkg::*;
#(
  parameter int unsigned             N_RGN      = 2,
  parameter logic [N_RGN*BYTE_W-1:0] RGN_BASE   = {8'h20, 8'h00},
  parameter logic [N_RGN*BYTE_W-1:0] RGN_LAST   = {8'h7F, 8'h1F},
  parameter bit                      RD_ACT_LOW = 1'b1,
  parameter bit                      WR_ACT_LOW = 1'b1,
  parameter bit                      CS_ACT_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tpa_i,
  input  logic [7:0]        abus_i,
  input  logic              rd_strb_i,
  input  logic              wr_strb_i,
  input  logic [7:0]        dbus_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [15:0]       addr_o,
  output logic [N_RGN-1:0]  cs_o,
  output logic              mem_we_o,
  output logic [15:0]       mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              dbus_oe_o,
  output logic [7:0]        dbus_o
);
  byte_t             hi_byte;
  byte_t             hi_cand;
  logic              tpa_fall;
  logic [N_RGN-1:0]  sel;
  logic              sel_any;
  logic              rd_act;
  logic              wr_act;

  assign rd_act = lvl_to_act(rd_strb_i, RD_ACT_LOW);
  assign wr_act = lvl_to_act(wr_strb_i, WR_ACT_LOW);

  hi_byte_latch #(.W(BYTE_W)) u_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .tpa_i     (tpa_i),
    .abus_i    (abus_i),
    .hi_o      (hi_byte),
    .hi_next_o (hi_cand),
    .fall_o    (tpa_fall)
  );

  range_decoder #(
    .W     (BYTE_W),
    .N     (N_RGN),
    .BASES (RGN_BASE),
    .LASTS (RGN_LAST)
  ) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tpa_fall),
    .page_i (hi_cand),
    .sel_o  (sel)
  );

  assign sel_any = |sel;
  assign addr_o  = {hi_byte, abus_i};

  wr_commit #(.AW(ADDR_W), .DW(BYTE_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_act_i  (wr_act),
    .sel_any_i (sel_any),
    .addr_i    (addr_o),
    .data_i    (dbus_i),
    .we_o      (mem_we_o),
    .waddr_o   (mem_waddr_o),
    .wdata_o   (mem_wdata_o)
  );

  // Only an asserted read strobe opens the drivers.
  assign dbus_oe_o = rd_act & sel_any;
  assign dbus_o    = dbus_oe_o ? mem_rdata_i : '0;

  for (genvar g = 0; g < N_RGN; g++) begin : g_cs
    if (CS_ACT_LOW) begin : g_low
      assign cs_o[g] = ~sel[g];
    end else begin : g_high
      assign cs_o[g] = sel[g];
    end
  end
endmodule

// File: rtl/mem_bus_if_chk.sv
module mem_bus_if_chk #(
  parameter int unsigned N_RGN      = 2,
  parameter bit          RD_ACT_LOW = 1'b1,
  parameter bit          WR_ACT_LOW = 1'b1,
  parameter bit          CS_ACT_LOW = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tpa_i,
  input logic [7:0]       abus_i,
  input logic             rd_strb_i,
  input logic             wr_strb_i,
  input logic [15:0]      addr_o,
  input logic [N_RGN-1:0] cs_o,
  input logic             mem_we_o,
  input logic             dbus_oe_o,
  input logic [7:0]       dbus_o
);
  logic             tpa_prev;
  logic [7:0]       abus_prev;
  logic             seen;
  logic             wr_prev, wr_prev2;
  logic             rd_on, wr_on, fall;
  logic [N_RGN-1:0] cs_on;

  assign rd_on = RD_ACT_LOW ? ~rd_strb_i : rd_strb_i;
  assign wr_on = WR_ACT_LOW ? ~wr_strb_i : wr_strb_i;
  assign cs_on = CS_ACT_LOW ? ~cs_o : cs_o;
  assign fall  = tpa_prev & ~tpa_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpa_prev  <= 1'b0;
      abus_prev <= '0;
      seen      <= 1'b0;
      wr_prev   <= 1'b0;
      wr_prev2  <= 1'b0;
    end else begin
      tpa_prev  <= tpa_i;
      abus_prev <= abus_i;
      seen      <= seen | fall;
      wr_prev   <= wr_on;
      wr_prev2  <= wr_prev;
    end
  end

  // R2
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (addr_o[15:8] == $past(abus_prev)));

  // R4
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_on));

  // R5
  no_sel_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (cs_on == '0));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(cs_on));

  // R6
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe_o |-> rd_on);

  // R6
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbus_oe_o |-> (dbus_o == 8'h00));

  // R7
  no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && !rd_on) |-> !dbus_oe_o);

  // R8
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  // R8
  we_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (wr_prev2 && !wr_prev));
endmodule

bind mem_bus_if mem_bus_if_chk #(
  .N_RGN      (N_RGN),
  .RD_ACT_LOW (RD_ACT_LOW),
  .WR_ACT_LOW (WR_ACT_LOW),
  .CS_ACT_LOW (CS_ACT_LOW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tpa_i     (tpa_i),
  .abus_i    (abus_i),
  .rd_strb_i (rd_strb_i),
  .wr_strb_i (wr_strb_i),
  .addr_o    (addr_o),
  .cs_o      (cs_o),
  .mem_we_o  (mem_we_o),
  .dbus_oe_o (dbus_oe_o),
  .dbus_o    (dbus_o)
);

// File: tb/tb_mem_bus_if.sv
`timescale 1ns/1ps
module tb_mem_bus_if;
  logic        clk;
  logic        rst_n;
  logic        tpa;
  logic [7:0]  abus;
  logic        rd_n, wr_n;
  logic [7:0]  dbus_in, rdata;
  logic [15:0] addr;
  logic [1:0]  cs_n;
  logic        we;
  logic [15:0] waddr;
  logic [7:0]  wdata;
  logic        oe;
  logic [7:0]  dbus_out;

  int unsigned n_chk;
  int unsigned n_bad;
  logic [1:0]  cur_sel;   // expected active-high selection
  logic [7:0]  cur_hi;

  mem_bus_if dut (
    .clk(clk), .rst_n(rst_n), .tpa_i(tpa), .abus_i(abus),
    .rd_strb_i(rd_n), .wr_strb_i(wr_n), .dbus_i(dbus_in),
    .mem_rdata_i(rdata), .addr_o(addr), .cs_o(cs_n), .mem_we_o(we),
    .mem_waddr_o(waddr), .mem_wdata_o(wdata), .dbus_oe_o(oe),
    .dbus_o(dbus_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Default map: 0x00-0x1F range 0, 0x20-0x7F range 1, else none.
  function automatic logic [1:0] exp_sel(input logic [7:0] hi);
    if (hi <= 8'h1F) return 2'b01;
    if (hi <= 8'h7F) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #3;
  endtask

  // One machine cycle. kind: 0 idle, 1 read, 2 write.
  task automatic mcycle(input logic [7:0] hi, input logic [7:0] lo,
                        input int kind, input logic [7:0] d);
    logic [1:0] es;
    es = exp_sel(hi);
    tick(); tpa = 1'b1; abus = hi; rd_n = 1'b1; wr_n = 1'b1;
    dbus_in = 8'($urandom); settle();
    check("R6 oe idle", {31'd0, oe}, 32'd0);
    check("R5 cs before edge", {30'd0, cs_n}, {30'd0, ~cur_sel});
    tick(); tpa = 1'b0; abus = lo; settle();
    check("R5 cs in edge cycle", {30'd0, cs_n}, {30'd0, ~cur_sel});
    check("R2 hi held", {24'd0, addr[15:8]}, {24'd0, cur_hi});
    tick(); settle();
    check("R2 R3 address", {16'd0, addr}, {16'd0, hi, lo});
    check("R4 R9 chip select", {30'd0, cs_n}, {30'd0, ~es});
    cur_sel = es; cur_hi = hi;
    if (kind == 0) begin
      abus = 8'($urandom); #0.5;
      check("R3 low live", {16'd0, addr}, {16'd0, hi, abus});
    end else if (kind == 1) begin
      tick(); rd_n = 1'b0; rdata = d; settle();
      check("R6 oe read", {31'd0, oe}, {31'd0, |es});
      check("R6 read data", {24'd0, dbus_out}, |es ? {24'd0, d} : 32'd0);
      tick(); rd_n = 1'b1; settle();
      check("R6 oe after read", {31'd0, oe}, 32'd0);
    end else begin
      tick(); dbus_in = d; settle();
      check("R7 no drive early write", {31'd0, oe}, 32'd0);
      tick(); wr_n = 1'b0; settle();
      check("R7 no drive in strobe", {31'd0, oe}, 32'd0);
      tick(); settle();
      check("R8 no we during strobe", {31'd0, we}, 32'd0);
      tick(); wr_n = 1'b1; dbus_in = ~d; abus = ~lo; settle();
      check("R8 we not yet", {31'd0, we}, 32'd0);
      tick(); settle();
      check("R8 we pulse", {31'd0, we}, {31'd0, |es});
      if (|es) begin
        check("R8 write address", {16'd0, waddr}, {16'd0, hi, lo});
        check("R8 write data", {24'd0, wdata}, {24'd0, d});
      end
      tick(); settle();
      check("R8 we one cycle", {31'd0, we}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    cur_sel = 2'b00; cur_hi = 8'h00;
    void'($urandom(32'd1234));
    rst_n = 1'b0; tpa = 1'b0; abus = 8'h5A; rd_n = 1'b1; wr_n = 1'b1;
    dbus_in = 8'h00; rdata = 8'hC3;
    repeat (3) tick();
    rst_n = 1'b1; settle();
    // R1 reset state
    check("R1 hi byte", {24'd0, addr[15:8]}, 32'd0);
    check("R1 R9 selects idle high", {30'd0, cs_n}, 32'd3);
    check("R1 oe", {31'd0, oe}, 32'd0);
    check("R1 we", {31'd0, we}, 32'd0);
    check("R1 dbus", {24'd0, dbus_out}, 32'd0);
    // R5: strobes before any pulse edge select nothing
    tick(); rd_n = 1'b0; settle();
    check("R5 R6 read before first edge", {31'd0, oe}, 32'd0);
    tick(); rd_n = 1'b1; wr_n = 1'b0; settle();
    tick(); wr_n = 1'b1; settle();
    tick(); settle();
    check("R5 R8 write before first edge", {31'd0, we}, 32'd0);
    check("R5 selects still off", {30'd0, cs_n}, 32'd3);
    // Directed boundaries of the map
    mcycle(8'h1F, 8'hFF, 1, 8'hA5);
    mcycle(8'h20, 8'h00, 1, 8'h3C);
    mcycle(8'h7F, 8'h10, 2, 8'h99);
    mcycle(8'h80, 8'h01, 1, 8'h77);
    mcycle(8'hFF, 8'h02, 2, 8'h66);
    mcycle(8'h00, 8'h00, 2, 8'h11);
    mcycle(8'h00, 8'h44, 0, 8'h00);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      mcycle(8'($urandom), 8'($urandom), int'($urandom % 3), 8'($urandom));
    end
    summary();
  end
endmodule